// File: doc/BRIEF.md
# External interrupt request controller

This block receives a set of asynchronous external interrupt lines and turns qualified edges on them into sticky per-channel event flags. Every line is synchronized by two flops and then cleaned by a glitch filter whose length is a single shared setting. The filter is a two-state machine per channel. In state HOLD its output matches the input, and a difference moves it to QUALIFY. When the setting is zero, HOLD updates the output at once instead. In QUALIFY, a return of the input to the old level goes back to HOLD and rejects the glitch. The new level held for the full length updates the output and also goes back to HOLD.

The filtered levels feed an edge stage. Per-channel rising and falling enables decide which transitions count as events. An event sets the channel flag. A per-channel route bit sends a set, enabled flag out either as an interrupt request or as a DMA request. In DMA routing, a done pulse from the DMA side clears the flag. When an event hits a channel whose flag is still set and whose overrun enable is on, a sticky overrun flag is set. All overrun flags are merged into one overrun request.

Software uses a small word-wide register port with one address, a write strobe and a combinational read path.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and irq_req, dma_req and ovr_req are low.
- R2: With filter length N (register 7, bits 3:0), a level is passed only after it has been stable for 2^N clock cycles. A pulse of 2^N cycles produces an event and a pulse of 2^N-1 cycles does not. N=0 passes even a one-cycle pulse.
- R3: A rising filtered edge sets the channel flag when its bit in register 5 is 1. A falling filtered edge sets it when its bit in register 6 is 1. With both bits 0, no edge sets the flag.
- R4: Writing 1 to a bit of register 0 clears that flag. Writing 0 leaves it unchanged.
- R5: irq_req[i] is high when flag i is set, request-enable bit i (register 1) is 1 and route bit i (register 2) is 0. dma_req[i] is then low.
- R6: dma_req[i] is high when flag i is set, enable bit i is 1 and route bit i is 1. A dma_done[i] pulse clears flag i only when route bit i is 1.
- R7: An event on a channel whose flag is already set sets overrun bit i (register 3) when overrun-enable bit i (register 4) is 1. Otherwise the overrun bit is left clear.
- R8: ovr_req is high while any overrun bit is set. Overrun bits are cleared only by writing 1 to them in register 3.
- R9: Register map: 0 flags, 1 request enable, 2 route, 3 overrun, 4 overrun enable, 5 rising enable, 6 falling enable, 7 filter length. Reads return the stored value, and register 7 returns only bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_CH | Asynchronous external request lines |
| dma_done | input | NUM_CH | Per-channel DMA completion pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | NUM_CH | Register write data |
| rd_data | output | NUM_CH | Register read data for addr |
| irq_req | output | NUM_CH | Per-channel interrupt requests |
| dma_req | output | NUM_CH | Per-channel DMA requests |
| ovr_req | output | 1 | Combined overrun request |

## Verification
Several properties are checked on every cycle: an event always leaves its flag set, an enabled event on a set flag always leaves an overrun bit, overrun bits stay set unless register 3 is written, and a channel never requests both interrupt and DMA. Other behaviour is only shown by the bench scenarios. These include the exact 2^N versus 2^N-1 pulse boundary at several filter lengths, the edge-enable choices, the write-one-to-clear behaviour and the route-dependent effect of dma_done.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic [2:0] {
        REG_FLAG   = 3'd0,
        REG_REQ_EN = 3'd1,
        REG_ROUTE  = 3'd2,
        REG_OVR    = 3'd3,
        REG_OVR_EN = 3'd4,
        REG_RISE   = 3'd5,
        REG_FALL   = 3'd6,
        REG_FLT    = 3'd7
    } reg_addr_e;

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter
    import eirq_pkg::*;
#(
    parameter int FLT_W = 4,
    parameter int CNT_W = (1 << FLT_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] flt_len,
    input  logic             din,
    output logic             dout
);
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;
    logic             diff;

    assign limit   = {{(CNT_W-1){1'b0}}, 1'b1} << flt_len;
    assign cnt_inc = cnt_q + 1'b1;
    assign diff    = (din != out_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (diff) begin
                    if (limit == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                        out_d = din;
                    end else begin
                        cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
                        state_d = FLT_QUAL;
                    end
                end
            end
            FLT_QUAL: begin
                if (!diff) begin
                    cnt_d   = '0;
                    state_d = FLT_HOLD;
                end else if (cnt_inc >= limit) begin
                    out_d   = din;
                    cnt_d   = '0;
                    state_d = FLT_HOLD;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            default: state_d = FLT_HOLD;
        endcase
    end

    assign dout = out_q;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int FLT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic [NUM_CH-1:0] evt,
    input  logic [NUM_CH-1:0] dma_done,
    output logic [NUM_CH-1:0] rd_data,
    output logic [NUM_CH-1:0] flag_q,
    output logic [NUM_CH-1:0] ovr_q,
    output logic [NUM_CH-1:0] req_en_q,
    output logic [NUM_CH-1:0] route_q,
    output logic [NUM_CH-1:0] ovr_en_q,
    output logic [NUM_CH-1:0] rise_en_q,
    output logic [NUM_CH-1:0] fall_en_q,
    output logic [FLT_W-1:0]  flt_len_q
);
    reg_addr_e         sel;
    logic [NUM_CH-1:0] clr_flag;
    logic [NUM_CH-1:0] clr_ovr;
    logic [NUM_CH-1:0] ovr_set;

    assign sel      = reg_addr_e'(addr);
    assign clr_flag = (wr_en && sel == REG_FLAG) ? wr_data : '0;
    assign clr_ovr  = (wr_en && sel == REG_OVR) ? wr_data : '0;
    assign ovr_set  = evt & flag_q & ovr_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q    <= '0;
            ovr_q     <= '0;
            req_en_q  <= '0;
            route_q   <= '0;
            ovr_en_q  <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            flt_len_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_flag & ~(dma_done & route_q)) | evt;
            ovr_q  <= (ovr_q & ~clr_ovr) | ovr_set;
            if (wr_en) begin
                unique case (sel)
                    REG_REQ_EN: req_en_q  <= wr_data;
                    REG_ROUTE:  route_q   <= wr_data;
                    REG_OVR_EN: ovr_en_q  <= wr_data;
                    REG_RISE:   rise_en_q <= wr_data;
                    REG_FALL:   fall_en_q <= wr_data;
                    REG_FLT:    flt_len_q <= wr_data[FLT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            REG_FLAG:   rd_data = flag_q;
            REG_REQ_EN: rd_data = req_en_q;
            REG_ROUTE:  rd_data = route_q;
            REG_OVR:    rd_data = ovr_q;
            REG_OVR_EN: rd_data = ovr_en_q;
            REG_RISE:   rd_data = rise_en_q;
            REG_FALL:   rd_data = fall_en_q;
            REG_FLT:    rd_data = {{(NUM_CH-FLT_W){1'b0}}, flt_len_q};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int NUM_CH = 16,
    parameter int FLT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_in,
    input  logic [NUM_CH-1:0] dma_done,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] rd_data,
    output logic [NUM_CH-1:0] irq_req,
    output logic [NUM_CH-1:0] dma_req,
    output logic              ovr_req
);
    localparam int CNT_W = (1 << FLT_W) + 1;

    logic [NUM_CH-1:0] sync_v;
    logic [NUM_CH-1:0] filt_v;
    logic [NUM_CH-1:0] filt_prev;
    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] flag_v;
    logic [NUM_CH-1:0] ovr_v;
    logic [NUM_CH-1:0] req_en_v;
    logic [NUM_CH-1:0] route_v;
    logic [NUM_CH-1:0] ovr_en_v;
    logic [NUM_CH-1:0] rise_en_v;
    logic [NUM_CH-1:0] fall_en_v;
    logic [FLT_W-1:0]  flt_len_v;

    eirq_sync #(.W(NUM_CH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (sync_v)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
        eirq_filter #(.FLT_W(FLT_W), .CNT_W(CNT_W)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .flt_len(flt_len_v),
            .din    (sync_v[ch]),
            .dout   (filt_v[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_prev <= '0;
        else        filt_prev <= filt_v;
    end

    assign evt = (filt_v & ~filt_prev & rise_en_v) | (~filt_v & filt_prev & fall_en_v);

    eirq_regs #(.NUM_CH(NUM_CH), .FLT_W(FLT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .evt      (evt),
        .dma_done (dma_done),
        .rd_data  (rd_data),
        .flag_q   (flag_v),
        .ovr_q    (ovr_v),
        .req_en_q (req_en_v),
        .route_q  (route_v),
        .ovr_en_q (ovr_en_v),
        .rise_en_q(rise_en_v),
        .fall_en_q(fall_en_v),
        .flt_len_q(flt_len_v)
    );

    assign irq_req = flag_v & req_en_v & ~route_v;
    assign dma_req = flag_v & req_en_v & route_v;
    assign ovr_req = |ovr_v;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [NUM_CH-1:0] evt,
    input logic [NUM_CH-1:0] flag_v,
    input logic [NUM_CH-1:0] ovr_v,
    input logic [NUM_CH-1:0] ovr_en_v,
    input logic [NUM_CH-1:0] irq_req,
    input logic [NUM_CH-1:0] dma_req,
    input logic              ovr_req
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_req == '0 && dma_req == '0 && !ovr_req));

    assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flag_v & $past(evt)) == $past(evt)));

    assert_route_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & dma_req) == '0));

    assert_overrun_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & flag_v & ovr_en_v) != '0)
        |=> ((ovr_v & $past(evt & flag_v & ovr_en_v)) == $past(evt & flag_v & ovr_en_v)));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr != 3'd3) |=> ((ovr_v & $past(ovr_v)) == $past(ovr_v)));
endmodule

bind ext_irq_ctrl eirq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .evt     (evt),
    .flag_v  (flag_v),
    .ovr_v   (ovr_v),
    .ovr_en_v(ovr_en_v),
    .irq_req (irq_req),
    .dma_req (dma_req),
    .ovr_req (ovr_req)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    localparam int NUM_CH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] irq_in = '0;
    logic [NUM_CH-1:0] dma_done = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        addr = '0;
    logic [NUM_CH-1:0] wr_data = '0;
    logic [NUM_CH-1:0] rd_data;
    logic [NUM_CH-1:0] irq_req;
    logic [NUM_CH-1:0] dma_req;
    logic              ovr_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ext_irq_ctrl #(.NUM_CH(NUM_CH), .FLT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dma_done(dma_done),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_req(irq_req), .dma_req(dma_req), .ovr_req(ovr_req)
    );

    // fields: {N[18:15], width[14:7], rise[6], fall[5], ch[4:1], expect[0]}
    localparam logic [18:0] VEC [0:7] = '{
        {4'd0, 8'd1,  1'b1, 1'b0, 4'd0,  1'b1},   // R2 N=0 one-cycle pulse
        {4'd3, 8'd7,  1'b1, 1'b0, 4'd1,  1'b0},   // R2 2^N-1 rejected
        {4'd3, 8'd8,  1'b1, 1'b0, 4'd1,  1'b1},   // R2 2^N passes
        {4'd2, 8'd3,  1'b1, 1'b1, 4'd2,  1'b0},   // R2 short glitch
        {4'd2, 8'd4,  1'b0, 1'b1, 4'd2,  1'b1},   // R3 falling only
        {4'd1, 8'd5,  1'b0, 1'b0, 4'd3,  1'b0},   // R3 no edge enabled
        {4'd4, 8'd16, 1'b1, 1'b0, 4'd15, 1'b1},   // R2 longest filter
        {4'd4, 8'd15, 1'b0, 1'b1, 4'd15, 1'b0}    // R2 longest, one short
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NUM_CH-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NUM_CH-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse(input int ch, input int w, input int settle);
        @(negedge clk);
        irq_in[ch] = 1'b1;
        repeat (w) @(negedge clk);
        irq_in[ch] = 1'b0;
        repeat (settle) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NUM_CH-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 register reset", 32'(d), 32'h0);
        end
        check("R1 outputs after reset", {irq_req, dma_req, 15'd0, ovr_req}, 32'h0);

        // table walk: R2 / R3
        for (int i = 0; i < 8; i++) begin
            int n, w, ch;
            n  = int'(VEC[i][18:15]);
            w  = int'(VEC[i][14:7]);
            ch = int'(VEC[i][4:1]);
            wr(3'd7, NUM_CH'(n));
            wr(3'd5, VEC[i][6] ? NUM_CH'(1) << ch : '0);
            wr(3'd6, VEC[i][5] ? NUM_CH'(1) << ch : '0);
            pulse(ch, w, (1 << n) + 12);
            rd(3'd0, d);
            check($sformatf("R2/R3 vector %0d flag", i), 32'(d),
                  VEC[i][0] ? 32'(1) << ch : 32'h0);
            wr(3'd0, '1);
        end
        wr(3'd6, '0);

        // R9 readback
        wr(3'd7, 16'hFFFF);
        rd(3'd7, d);
        check("R9 filter length reads 4 bits", 32'(d), 32'h000F);
        wr(3'd1, 16'hA5A5);
        rd(3'd1, d);
        check("R9 enable readback", 32'(d), 32'hA5A5);
        wr(3'd7, '0);
        wr(3'd1, '0);

        // R5 / R6 routing on channel 4
        wr(3'd5, 16'h0010);
        pulse(4, 2, 10);
        wr(3'd1, 16'h0010);
        @(negedge clk);
        check("R5 irq_req on interrupt route", 32'(irq_req), 32'h0010);
        check("R5 dma_req low on interrupt route", 32'(dma_req), 32'h0);
        wr(3'd2, 16'h0010);
        @(negedge clk);
        check("R6 dma_req on DMA route", {irq_req, dma_req}, 32'h0000_0010);
        @(negedge clk) dma_done = 16'h0010;
        @(negedge clk) dma_done = '0;
        rd(3'd0, d);
        check("R6 dma_done clears flag", 32'(d), 32'h0);
        check("R6 dma_req drops", 32'(dma_req), 32'h0);

        // R6 dma_done ignored under interrupt route, then R4 W1C
        wr(3'd2, '0);
        wr(3'd5, 16'h0020);
        pulse(5, 2, 10);
        @(negedge clk) dma_done = 16'h0020;
        @(negedge clk) dma_done = '0;
        rd(3'd0, d);
        check("R6 dma_done ignored on interrupt route", 32'(d), 32'h0020);
        wr(3'd0, 16'h0000);
        rd(3'd0, d);
        check("R4 writing zero keeps flag", 32'(d), 32'h0020);
        wr(3'd0, 16'h0020);
        rd(3'd0, d);
        check("R4 writing one clears flag", 32'(d), 32'h0);

        // R7 / R8 overrun
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'h00C0);
        pulse(6, 2, 10);
        pulse(6, 2, 10);
        pulse(7, 2, 10);
        pulse(7, 2, 10);
        rd(3'd3, d);
        check("R7 overrun only where enabled", 32'(d), 32'h0040);
        rd(3'd0, d);
        check("R7 flags of both channels", 32'(d), 32'h00C0);
        check("R8 combined overrun high", 32'(ovr_req), 32'h1);
        wr(3'd0, 16'h00C0);
        repeat (5) @(negedge clk);
        check("R8 overrun survives flag clear", 32'(ovr_req), 32'h1);
        wr(3'd3, 16'h0040);
        rd(3'd3, d);
        check("R8 overrun W1C", 32'(d), 32'h0);
        check("R8 combined overrun low", 32'(ovr_req), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule